// File: doc/BRIEF.md
# Single-Wire Master Read Bit Frame

This block runs one read bit frame from the master side of an open-drain single-wire bus. On a start pulse it pulls the line low, which wakes the target's internal timing. It holds the line low for a request interval and then lets go. If the target is answering with a 0 (a data 0 or an ACK), it joins in pulling the line low and keeps it low for a while after the master lets go. If it is answering with a 1 (a data 1 or a NACK), it never touches the line, and the pull-up raises it once the master lets go.

The master looks at the line level once, at a fixed point after the release and before the target's hold time runs out. A low level gives 0 and a high level gives 1. The frame then runs to the end of a full bit period, which includes line recovery, before it reports the bit with a single-cycle done pulse. Data reads and acknowledge reads use the same frame.

All timing is counted in clock cycles from the frame's first cycle. The cycle after the clock edge that accepts the start is cycle 0. The raw line input passes through a two-stage synchronizer inside the block. The capture point is placed so that the bit reflects the raw line level during cycle `SAMPLE_CYC`. Elaboration stops with an error if the timing parameters are ordered wrongly.

Top module: `swire_rd_frame`

## Requirements
- R1: While reset is held and after it is released with no start, `drv_low_o` is 0, `done_o` is 0 and `bit_o` is 1.
- R2: A start accepted while idle makes `drv_low_o` 1 for exactly `REQ_CYC` cycles (cycles 0 to `REQ_CYC`-1) and 0 for the rest of the frame.
- R3: If the raw line `line_i` is low during cycle `SAMPLE_CYC` of the frame, the reported bit is 0. This includes the case where the target releases the line one cycle after that point.
- R4: If `line_i` is high during cycle `SAMPLE_CYC`, the reported bit is 1. This includes a target that never drives the line and one that releases exactly at cycle `SAMPLE_CYC`.
- R5: A start pulse that arrives while a frame is in progress, up to and including the frame's last cycle, has no effect. It does not restart or extend the frame, and it does not begin a new one.
- R6: `done_o` is 1 only in cycle `BIT_CYC` of the frame and only for that one cycle. `bit_o` holds the captured value from then until the next frame's capture.
- R7: A start given in the cycle where `done_o` is 1 is accepted, so frames can run back to back.
- R8: The parameters must satisfy 1 <= `REQ_CYC` < `SAMPLE_CYC` < `HOLD0_CYC` and `SAMPLE_CYC` + 2 < `BIT_CYC`. Any other ordering is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one read frame (accepted only when idle) |
| line_i | input | 1 | Raw bus line level, asynchronous |
| drv_low_o | output | 1 | Open-drain pull-down enable for the bus line |
| done_o | output | 1 | One-cycle pulse at the end of the frame |
| bit_o | output | 1 | Received bit, valid with done_o |

## Verification
The hardest cases to reach are the ones where the target lets go of the line right at the sample point or one cycle later. They decide whether the synchronizer latency was folded into the capture point correctly. The bench models the target on the line and releases its pull-down at a chosen cycle of the frame. Releasing at cycle `SAMPLE_CYC` must read 1, and releasing at `SAMPLE_CYC`+1 must read 0. A start pulse placed in the final frame cycle, followed by a start in the done cycle, covers both sides of the restart boundary.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic {
    SWR_IDLE  = 1'b0,
    SWR_FRAME = 1'b1
  } swr_state_e;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  // Idle bus level is high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b1;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/swr_frame_ctl.sv
module swr_frame_ctl
  import swr_pkg::*;
#(
  parameter int unsigned REQ_CYC     = 4,
  parameter int unsigned SAMPLE_CYC  = 8,
  parameter int unsigned BIT_CYC     = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic line_s_i,
  output logic busy_o,
  output logic drv_low_o,
  output logic done_o,
  output logic bit_o
);
  localparam int unsigned CW     = $clog2(BIT_CYC + 1);
  localparam int unsigned CAP_AT = SAMPLE_CYC + SYNC_STAGES;

  swr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          drv_q, drv_d;
  logic          done_q, done_d;
  logic          bit_q, bit_d;
  logic          cnt_en;

  assign cnt_en = (state_q == SWR_FRAME);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    drv_d   = drv_q;
    done_d  = 1'b0;
    bit_d   = bit_q;
    unique case (state_q)
      SWR_IDLE: begin
        if (start_i) begin
          state_d = SWR_FRAME;
          cnt_d   = '0;
          drv_d   = 1'b1;
        end
      end
      SWR_FRAME: begin
        if (cnt_en) cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(REQ_CYC - 1)) drv_d = 1'b0;
        if (cnt_q == CW'(CAP_AT))      bit_d = line_s_i;
        if (cnt_q == CW'(BIT_CYC - 1)) begin
          state_d = SWR_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SWR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SWR_IDLE;
      cnt_q   <= '0;
      drv_q   <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drv_q   <= drv_d;
      done_q  <= done_d;
      bit_q   <= bit_d;
    end
  end

  assign busy_o    = (state_q == SWR_FRAME);
  assign drv_low_o = drv_q;
  assign done_o    = done_q;
  assign bit_o     = bit_q;

  // R2: the line is only pulled low inside a frame
  a_r2_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    drv_low_o |-> busy_o);

  // R5: a running frame advances one count per cycle whatever start does
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || cnt_q == $past(cnt_q) + 1'b1));

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: done follows a frame, and the bit holds while idle
  a_r6_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));

  a_r6_bit_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(bit_o));
endmodule

// File: rtl/swire_rd_frame.sv
module swire_rd_frame #(
  parameter int unsigned REQ_CYC    = 4,
  parameter int unsigned SAMPLE_CYC = 8,
  parameter int unsigned HOLD0_CYC  = 12,
  parameter int unsigned BIT_CYC    = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic line_i,
  output logic drv_low_o,
  output logic done_o,
  output logic bit_o
);
  localparam int unsigned SYNC_STAGES = 2;

  // R8: the sample point must lie after release and before the hold-0 bound,
  // and the synchronized capture must land inside the bit period.
  if (!(REQ_CYC >= 1 && REQ_CYC < SAMPLE_CYC && SAMPLE_CYC < HOLD0_CYC &&
        SAMPLE_CYC + SYNC_STAGES < BIT_CYC)) begin : g_bad_timing
    $error("swire_rd_frame: timing parameters out of order");
  end

  logic line_s;
  logic busy;

  swr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (line_i),
    .sync_o  (line_s)
  );

  swr_frame_ctl #(
    .REQ_CYC     (REQ_CYC),
    .SAMPLE_CYC  (SAMPLE_CYC),
    .BIT_CYC     (BIT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .line_s_i  (line_s),
    .busy_o    (busy),
    .drv_low_o (drv_low_o),
    .done_o    (done_o),
    .bit_o     (bit_o)
  );
endmodule

// File: tb/sim_swire_rd_frame.sv
module sim_swire_rd_frame;
  localparam int REQ    = 4;
  localparam int SAMPLE = 8;
  localparam int HOLD0  = 12;
  localparam int BITP   = 30;

  logic clk, rst_n, start, tgt_low;
  logic drv_low, done, bitv;
  logic line;
  int   n_chk, n_bad;

  assign line = ~(drv_low | tgt_low);

  swire_rd_frame #(.REQ_CYC(REQ), .SAMPLE_CYC(SAMPLE), .HOLD0_CYC(HOLD0),
                   .BIT_CYC(BITP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .line_i(line),
    .drv_low_o(drv_low), .done_o(done), .bit_o(bitv));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One frame. rel_k: cycle where the target lets go (-1: never drives).
  // ign_k: cycle where a stray start is pulsed (-1: none).
  task automatic run_frame(input int rel_k, input int ign_k, input logic exp);
    start = 1'b1;
    for (int k = 0; k <= BITP; k++) begin
      @(negedge clk);
      if (k == 0) tgt_low = (rel_k >= 0);
      if (k == rel_k) tgt_low = 1'b0;
      start = (k == ign_k);
      chk("R2 drive window", drv_low, (k < REQ));
      chk("R6 done timing", done, (k == BITP));
      if (k == BITP) chk((exp ? "R4 read one" : "R3 read zero"), bitv, exp);
    end
    tgt_low = 1'b0;
  endtask

  task automatic idle_check(input int n, input logic held);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R5 stray start ignored", drv_low, 1'b0);
      chk("R6 done single", done, 1'b0);
      chk("R6 bit held", bitv, held);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    start = 1'b0; tgt_low = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset drv", drv_low, 1'b0);
    chk("R1 reset done", done, 1'b0);
    chk("R1 reset bit", bitv, 1'b1);
    rst_n = 1'b1;
    idle_check(3, 1'b1);
    chk("R8 parameter order", (REQ < SAMPLE && SAMPLE < HOLD0 && SAMPLE + 2 < BITP), 1'b1);
    run_frame(HOLD0, -1, 1'b0);       // R3 full hold-0 response
    run_frame(-1, -1, 1'b1);          // R4 no response, R7 back to back
    run_frame(SAMPLE + 1, -1, 1'b0);  // R3 release just after sample
    run_frame(SAMPLE, -1, 1'b1);      // R4 release at sample point
    run_frame(HOLD0, 5, 1'b0);        // R5 stray start mid-frame
    run_frame(-1, BITP - 1, 1'b1);    // R5 stray start in last cycle
    idle_check(4, 1'b1);
    run_frame(HOLD0, -1, 1'b0);       // R7 start after idle
    idle_check(2, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule